// File: doc/BRIEF.md
# Single-Cycle Accumulator Instruction Controller

This block is the control unit of a small accumulator processor whose instructions are each one byte long. A byte arrives on `instr_i`. The controller captures it on the falling clock edge and splits it into a 4-bit opcode in the upper half and a 4-bit operand in the lower half. Before the next rising edge it drives every control line: the ALU enables, the register-file write enables, the data-memory address and strobes, the pointer and link register updates, and the branch decision. On the rising edge the instruction takes effect. The program counter and the stack pointer are held inside the controller. Every other piece of storage, and the ALU itself, sits outside the block and only follows these control lines.

Opcodes with the top bit clear go to the ALU. The lower three opcode bits select the operation and the operand is passed along unchanged. Opcodes with the top bit set cover the following:
- copying the accumulator into a numbered register;
- 16-bit moves among four wide registers;
- nibble-immediate builds of the accumulator;
- loads and stores at the pointer register plus an unsigned 4-bit offset;
- conditional jumps, with or without a link.

A jump with link also saves the return address, hands the stack pointer to the pointer register and steps the stack pointer by a fixed amount. The direction of that step follows a return flag.

Top module: `acc_seq_ctrl`

## Requirements
- R1: While reset is low, and after its release until the first falling edge, PC equals PC_RESET (0), SP equals SP_RESET (0xFFF0), and no enable, strobe or taken output is high.
- R2: An instruction on `instr_i` is captured on a falling edge and its decoded outputs are valid from then on. PC and SP take their new values only at the following rising edge.
- R3: Opcode 0xxx asserts `alu_en_o`. `alu_op_o` equals the lower three opcode bits and `alu_arg_o` equals the operand.
- R4: Opcode 1000 asserts `reg_we_o` with `reg_wsel_o` equal to the operand. For operand 1111 (the constant-zero register) no write is requested.
- R5: Opcode 1001 moves one wide register to another. The destination code is operand[3:2] and the source code is operand[1:0], with PC=00, SP=01, pointer=10 and link=11. A move to pointer or link raises that register's write enable with the source value. A move to PC or SP loads it at the rising edge, and PC does not increment.
- R6: Opcode 1010 requests an accumulator write of {acc[7:4], operand}. Opcode 1011 requests {operand, acc[3:0]}.
- R7: Opcode 1100 drives `addr_o` = pointer + operand (unsigned, modulo 2^16), asserts `mem_rd_o`, and requests an accumulator write of `rdata_i`.
- R8: Opcode 1101 drives the same address, asserts `mem_wr_o` with `wdata_o` equal to the accumulator. `mem_wr_o` is high for no other opcode.
- R9: Jump conditions use flags_i = {N,Z,C,V} (bit 3 down to bit 0). The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 !(!Z&(N==V)), and 14 and 15 always.
- R10: Opcode 1110 with its condition true raises `taken_o` and loads PC from the pointer register.
- R11: Opcode 1111 with its condition true writes PC+1 to link and the old SP to pointer, and loads PC from pointer. SP moves by +16 if `ret_flag_i` is high, otherwise by -16, modulo 2^16. When the condition is false, none of these writes happen.
- R12: Every other executed instruction, including a jump that is not taken, advances PC by one.
- R13: At most one of ALU enable, register write, memory read, memory write and taken is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: fetch on falling edge, execute on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 8 | Instruction byte at the current PC |
| flags_i | input | 4 | Flags {N,Z,C,V} |
| ret_flag_i | input | 1 | Return flag: selects stack step direction |
| acc_i | input | 8 | Accumulator value |
| rdata_i | input | 8 | Data bus read value |
| ptr_i | input | 16 | Pointer (base / jump target) register value |
| link_i | input | 16 | Link register value |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| alu_en_o | output | 1 | ALU executes this cycle |
| alu_op_o | output | 3 | ALU operation select |
| alu_arg_o | output | 4 | Second-operand register index or shift amount |
| reg_we_o | output | 1 | Copy accumulator into a register |
| reg_wsel_o | output | 4 | Destination register index |
| acc_we_o | output | 1 | Accumulator write enable |
| acc_d_o | output | 8 | Accumulator write value |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| addr_o | output | 16 | Data memory address |
| wdata_o | output | 8 | Data memory write value |
| ptr_we_o | output | 1 | Pointer register write enable |
| ptr_d_o | output | 16 | Pointer register write value |
| link_we_o | output | 1 | Link register write enable |
| link_d_o | output | 16 | Link register write value |
| taken_o | output | 1 | Jump taken this cycle |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address width, SP_RESET of 0xFFF0 and a stack step of 16. With a reset stack pointer sixteen below the top of the address space, the first upward step of a linked jump wraps to zero and the next downward step wraps back. The 16-bit pointer also lets a load from 0xFFFE plus 3 show the address wrapping to 0x0001. Every condition code is driven against all sixteen flag patterns.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    // Upper-range opcodes; the lower half (top bit clear) belongs to the ALU
    localparam logic [NIB_W-1:0] OP_PUT   = 4'h8;
    localparam logic [NIB_W-1:0] OP_WIDE  = 4'h9;
    localparam logic [NIB_W-1:0] OP_NLO   = 4'hA;
    localparam logic [NIB_W-1:0] OP_NHI   = 4'hB;
    localparam logic [NIB_W-1:0] OP_LOAD  = 4'hC;
    localparam logic [NIB_W-1:0] OP_STORE = 4'hD;
    localparam logic [NIB_W-1:0] OP_JUMP  = 4'hE;
    localparam logic [NIB_W-1:0] OP_CALL  = 4'hF;

    localparam logic [NIB_W-1:0] ZERO_REG = 4'hF;

    typedef enum logic [1:0] {
        WR_PC   = 2'b00,
        WR_SP   = 2'b01,
        WR_PTR  = 2'b10,
        WR_LINK = 2'b11
    } wreg_e;

    typedef struct packed {
        logic             alu_en;
        logic [2:0]       alu_op;
        logic             reg_we;
        logic             wide_mv;
        wreg_e            wdst;
        wreg_e            wsrc;
        logic             nib_lo;
        logic             nib_hi;
        logic             mem_rd;
        logic             mem_wr;
        logic             jump;
        logic             call;
        logic [NIB_W-1:0] arg;
    } ctrl_t;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  logic              vld,
    input  logic [BYTE_W-1:0] ir,
    output ctrl_t             ctrl
);
    logic [NIB_W-1:0] op;
    logic [NIB_W-1:0] arg;

    assign op  = ir[BYTE_W-1:NIB_W];
    assign arg = ir[NIB_W-1:0];

    always_comb begin
        ctrl = '0;
        if (vld) begin
            ctrl.arg = arg;
            if (!op[NIB_W-1]) begin
                ctrl.alu_en = 1'b1;
                ctrl.alu_op = op[2:0];
            end else begin
                unique case (op)
                    OP_PUT:   ctrl.reg_we = (arg != ZERO_REG);
                    OP_WIDE: begin
                        ctrl.wide_mv = 1'b1;
                        ctrl.wdst    = wreg_e'(arg[3:2]);
                        ctrl.wsrc    = wreg_e'(arg[1:0]);
                    end
                    OP_NLO:   ctrl.nib_lo = 1'b1;
                    OP_NHI:   ctrl.nib_hi = 1'b1;
                    OP_LOAD:  ctrl.mem_rd = 1'b1;
                    OP_STORE: ctrl.mem_wr = 1'b1;
                    OP_JUMP:  ctrl.jump   = 1'b1;
                    OP_CALL:  ctrl.call   = 1'b1;
                    default:  ctrl        = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/acc_seq_cond.sv
module acc_seq_cond
    import acc_seq_pkg::*;
(
    input  logic [NIB_W-1:0] code,
    input  logic [3:0]       flags,   // {N,Z,C,V}
    output logic             hold
);
    logic n, z, c, v;
    logic base;

    assign n = flags[3];
    assign z = flags[2];
    assign c = flags[1];
    assign v = flags[0];

    // Even codes name a test; the odd neighbour inverts it; the last pair is unconditional
    always_comb begin
        unique case (code[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c & ~z;
            3'd5:    base = (n == v);
            3'd6:    base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        hold = (code[3:1] == 3'd7) ? 1'b1 : (base ^ code[0]);
    end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          SP_STEP  = 16,
    parameter logic [AW-1:0] SP_RESET = 16'hFFF0,
    parameter logic [AW-1:0] PC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] instr_i,
    input  logic [3:0]        flags_i,
    input  logic              ret_flag_i,
    input  logic [BYTE_W-1:0] acc_i,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic [AW-1:0]     ptr_i,
    input  logic [AW-1:0]     link_i,
    output logic [AW-1:0]     pc_o,
    output logic [AW-1:0]     sp_o,
    output logic              alu_en_o,
    output logic [2:0]        alu_op_o,
    output logic [NIB_W-1:0]  alu_arg_o,
    output logic              reg_we_o,
    output logic [NIB_W-1:0]  reg_wsel_o,
    output logic              acc_we_o,
    output logic [BYTE_W-1:0] acc_d_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [AW-1:0]     addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              ptr_we_o,
    output logic [AW-1:0]     ptr_d_o,
    output logic              link_we_o,
    output logic [AW-1:0]     link_d_o,
    output logic              taken_o
);
    localparam logic [AW-1:0] STEP = AW'(SP_STEP);
    localparam logic [AW-1:0] ONE  = AW'(1);

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] ir;
    } fetch_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
    } state_t;

    fetch_t fetch_d, fetch_q;
    state_t st_d, st_q;
    ctrl_t  ctrl;
    logic   cond_hold;
    logic   taken;
    logic   call_taken;
    logic [AW-1:0] wval;
    logic [AW-1:0] pc_inc;

    // Falling edge: capture the instruction byte
    always_comb begin
        fetch_d.vld = 1'b1;
        fetch_d.ir  = instr_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fetch_q <= '0;
        else        fetch_q <= fetch_d;
    end

    acc_seq_decode u_dec (
        .vld  (fetch_q.vld),
        .ir   (fetch_q.ir),
        .ctrl (ctrl)
    );

    acc_seq_cond u_cond (
        .code  (ctrl.arg),
        .flags (flags_i),
        .hold  (cond_hold)
    );

    assign taken      = (ctrl.jump | ctrl.call) & cond_hold;
    assign call_taken = ctrl.call & cond_hold;
    assign pc_inc     = st_q.pc + ONE;

    always_comb begin
        unique case (ctrl.wsrc)
            WR_PC:   wval = st_q.pc;
            WR_SP:   wval = st_q.sp;
            WR_PTR:  wval = ptr_i;
            default: wval = link_i;
        endcase
    end

    // Rising edge: next program counter and stack pointer
    always_comb begin
        st_d = st_q;
        if (fetch_q.vld) st_d.pc = pc_inc;
        if (taken)       st_d.pc = ptr_i;
        if (call_taken)  st_d.sp = ret_flag_i ? st_q.sp + STEP : st_q.sp - STEP;
        if (ctrl.wide_mv && ctrl.wdst == WR_PC) st_d.pc = wval;
        if (ctrl.wide_mv && ctrl.wdst == WR_SP) st_d.sp = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= PC_RESET;
            st_q.sp <= SP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pc_o       = st_q.pc;
        sp_o       = st_q.sp;
        alu_en_o   = ctrl.alu_en;
        alu_op_o   = ctrl.alu_op;
        alu_arg_o  = ctrl.alu_en ? ctrl.arg : '0;
        reg_we_o   = ctrl.reg_we;
        reg_wsel_o = ctrl.reg_we ? ctrl.arg : '0;
        mem_rd_o   = ctrl.mem_rd;
        mem_wr_o   = ctrl.mem_wr;
        addr_o     = (ctrl.mem_rd | ctrl.mem_wr) ? ptr_i + AW'(ctrl.arg) : '0;
        wdata_o    = ctrl.mem_wr ? acc_i : '0;
        acc_we_o   = ctrl.nib_lo | ctrl.nib_hi | ctrl.mem_rd;
        if (ctrl.nib_lo)      acc_d_o = {acc_i[BYTE_W-1:NIB_W], ctrl.arg};
        else if (ctrl.nib_hi) acc_d_o = {ctrl.arg, acc_i[NIB_W-1:0]};
        else if (ctrl.mem_rd) acc_d_o = rdata_i;
        else                  acc_d_o = '0;
        ptr_we_o   = call_taken | (ctrl.wide_mv && ctrl.wdst == WR_PTR);
        ptr_d_o    = call_taken ? st_q.sp : (ptr_we_o ? wval : '0);
        link_we_o  = call_taken | (ctrl.wide_mv && ctrl.wdst == WR_LINK);
        link_d_o   = call_taken ? pc_inc : (link_we_o ? wval : '0);
        taken_o    = taken;
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_q.vld |=> (pc_o == $past(pc_o)) && (sp_o == $past(sp_o)));

    // R12
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_q.vld && !taken_o && !(ctrl.wide_mv && ctrl.wdst == WR_PC))
        |=> pc_o == $past(pc_o) + ONE);

    // R10
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> pc_o == $past(ptr_i));

    // R11
    stack_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && link_we_o && ptr_we_o)
        |=> sp_o == ($past(ret_flag_i) ? $past(sp_o) + STEP : $past(sp_o) - STEP));

    // R4
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> reg_wsel_o != ZERO_REG);

    // R13
    unit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alu_en_o, reg_we_o, mem_rd_o, mem_wr_o, taken_o}));

endmodule

// File: tb/sim_acc_seq_ctrl.sv
module sim_acc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  instr_i;
    logic [3:0]  flags_i;
    logic        ret_flag_i;
    logic [7:0]  acc_i, rdata_i;
    logic [15:0] ptr_i, link_i;
    logic [15:0] pc_o, sp_o, addr_o, ptr_d_o, link_d_o;
    logic        alu_en_o, reg_we_o, acc_we_o, mem_rd_o, mem_wr_o;
    logic        ptr_we_o, link_we_o, taken_o;
    logic [2:0]  alu_op_o;
    logic [3:0]  alu_arg_o, reg_wsel_o;
    logic [7:0]  acc_d_o, wdata_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [15:0] exp_pc, exp_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .flags_i(flags_i),
        .ret_flag_i(ret_flag_i), .acc_i(acc_i), .rdata_i(rdata_i),
        .ptr_i(ptr_i), .link_i(link_i), .pc_o(pc_o), .sp_o(sp_o),
        .alu_en_o(alu_en_o), .alu_op_o(alu_op_o), .alu_arg_o(alu_arg_o),
        .reg_we_o(reg_we_o), .reg_wsel_o(reg_wsel_o), .acc_we_o(acc_we_o),
        .acc_d_o(acc_d_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .addr_o(addr_o), .wdata_o(wdata_o), .ptr_we_o(ptr_we_o),
        .ptr_d_o(ptr_d_o), .link_we_o(link_we_o), .link_d_o(link_d_o),
        .taken_o(taken_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic cond_ok(input logic [3:0] code, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (code)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !(c && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    // Drive a byte and wait until it has been fetched (falling edge)
    task automatic fetch(input logic [7:0] ins);
        instr_i = ins;
        @(negedge clk); #1;
    endtask

    // Wait for execution (rising edge) and compare PC/SP with the model
    task automatic commit(input string req);
        @(posedge clk); #1;
        chk({req, " pc"}, pc_o, exp_pc);
        chk({req, " sp"}, sp_o, exp_sp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; instr_i = 8'h00; flags_i = 4'h0; ret_flag_i = 1'b0;
        acc_i = 8'h00; rdata_i = 8'h00; ptr_i = 16'h0; link_i = 16'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pc", pc_o, 16'h0000);
        chk("R1 reset sp", sp_o, 16'hFFF0);
        chk("R1 reset alu_en", alu_en_o, 0);
        rst_n = 1'b1;
        #1;
        chk("R1 idle enables", {alu_en_o, reg_we_o, acc_we_o, mem_rd_o, mem_wr_o,
                                ptr_we_o, link_we_o, taken_o}, 0);
        exp_pc = 16'h0000;
        exp_sp = 16'hFFF0;
    endtask

    task automatic t_alu;
        for (int op = 0; op < 8; op++) begin
            logic [3:0] a;
            a = 4'(op * 3 + 1);
            fetch({1'b0, 3'(op), a});
            chk("R3 alu_en", alu_en_o, 1);
            chk("R3 alu_op", alu_op_o, op);
            chk("R3 alu_arg", alu_arg_o, a);
            chk("R13 other units idle", {reg_we_o, mem_rd_o, mem_wr_o, taken_o}, 0);
            chk("R2 pc before rising edge", pc_o, exp_pc);
            exp_pc = exp_pc + 16'd1;
            commit("R12 alu");
        end
    endtask

    task automatic t_put;
        fetch(8'h82);
        chk("R4 reg_we", reg_we_o, 1);
        chk("R4 reg_wsel", reg_wsel_o, 4'h2);
        exp_pc++; commit("R12 put");
        fetch(8'h8F);
        chk("R4 zero register not written", reg_we_o, 0);
        exp_pc++; commit("R12 put zero");
    endtask

    task automatic t_nibble;
        acc_i = 8'h3C;
        fetch(8'hA5);
        chk("R6 low we", acc_we_o, 1);
        chk("R6 low value", acc_d_o, 8'h35);
        exp_pc++; commit("R12 nlo");
        fetch(8'hB9);
        chk("R6 high we", acc_we_o, 1);
        chk("R6 high value", acc_d_o, 8'h9C);
        exp_pc++; commit("R12 nhi");
    endtask

    task automatic t_load;
        ptr_i = 16'h1000; rdata_i = 8'h77;
        fetch(8'hC3);
        chk("R7 addr", addr_o, 16'h1003);
        chk("R7 rd", mem_rd_o, 1);
        chk("R7 acc we", acc_we_o, 1);
        chk("R7 acc data", acc_d_o, 8'h77);
        chk("R8 no write on load", mem_wr_o, 0);
        exp_pc++; commit("R12 load");
        ptr_i = 16'hFFFE;
        fetch(8'hC3);
        chk("R7 addr wrap", addr_o, 16'h0001);
        exp_pc++; commit("R12 load wrap");
    endtask

    task automatic t_store;
        ptr_i = 16'h2200; acc_i = 8'hA1;
        fetch(8'hD4);
        chk("R8 addr", addr_o, 16'h2204);
        chk("R8 wr", mem_wr_o, 1);
        chk("R8 wdata", wdata_o, 8'hA1);
        chk("R13 no read/acc on store", {mem_rd_o, acc_we_o}, 0);
        exp_pc++; commit("R12 store");
    endtask

    task automatic t_cond;
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                logic t;
                flags_i = 4'(f);
                ptr_i = 16'h4000 + 16'(code * 16 + f);
                t = cond_ok(4'(code), 4'(f));
                fetch({4'hE, 4'(code)});
                chk("R9 condition", taken_o, t);
                chk("R10 jump writes no link", link_we_o, 0);
                exp_pc = t ? ptr_i : exp_pc + 16'd1;
                commit(t ? "R10 jump" : "R12 not taken");
            end
        end
        flags_i = 4'h0;
    endtask

    task automatic t_call;
        ptr_i = 16'h2000; ret_flag_i = 1'b1;
        fetch(8'hFE);
        chk("R11 link we", link_we_o, 1);
        chk("R11 link data", link_d_o, exp_pc + 16'd1);
        chk("R11 ptr we", ptr_we_o, 1);
        chk("R11 ptr data", ptr_d_o, exp_sp);
        exp_pc = 16'h2000; exp_sp = exp_sp + 16'd16;
        commit("R11 call ret up wrap");
        chk("R11 sp wrapped to zero", sp_o, 16'h0000);
        ptr_i = 16'h2100; ret_flag_i = 1'b0;
        fetch(8'hFF);
        chk("R11 ptr data", ptr_d_o, exp_sp);
        exp_pc = 16'h2100; exp_sp = exp_sp - 16'd16;
        commit("R11 call down");
        flags_i = 4'b0100;
        fetch(8'hF1);
        chk("R11 not taken no writes", {taken_o, link_we_o, ptr_we_o}, 0);
        exp_pc++;
        commit("R11 not taken");
        flags_i = 4'h0;
    endtask

    task automatic t_wide;
        fetch(8'h99);
        chk("R5 ptr we", ptr_we_o, 1);
        chk("R5 ptr from sp", ptr_d_o, exp_sp);
        exp_pc++; commit("R5 mv ptr");
        link_i = 16'h3456;
        fetch(8'h93);
        chk("R5 no unit on pc move", {ptr_we_o, link_we_o, taken_o}, 0);
        exp_pc = 16'h3456; commit("R5 pc from link");
        ptr_i = 16'h7770;
        fetch(8'h96);
        exp_pc++; exp_sp = 16'h7770; commit("R5 sp from ptr");
        fetch(8'h9D);
        chk("R5 link we", link_we_o, 1);
        chk("R5 link from sp", link_d_o, 16'h7770);
        exp_pc++; commit("R5 mv link");
        fetch(8'h90);
        commit("R5 pc to itself holds");
    endtask

    initial begin
        t_reset();
        t_alu();
        t_put();
        t_nibble();
        t_load();
        t_store();
        t_cond();
        t_call();
        t_wide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule